// File: doc/BRIEF.md
# Burst Transfer Address Sequencer

This block sits on the initiator side of a pipelined system bus and produces the address phase for every beat of a burst. A requester supplies a start address, a beat size code, a burst kind and a direction. The sequencer presents the first beat as a non-sequential transfer. It then walks the address beat by beat and labels each following beat as sequential. It advances only on clock edges where the bus signals ready.

Single transfers are supported, as are undefined-length incrementing bursts and fixed bursts of 4, 8 or 16 beats in both incrementing and wrapping form. The beat size is a power of two bytes, from 1 to 128. The requester can stall a burst between beats; the sequencer then shows a busy transfer type while the pending beat's address stays on the bus. A one-cycle completion pulse follows acceptance of the final beat. Reset is synchronous and active high.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows transfer type IDLE (2'b00) and `burst_done` low.
- R2: When idle, a request (`req_start` high) is taken only on an edge with `bus_ready` high. The next cycle shows type NONSEQ (2'b10), `bus_addr` equal to `req_addr`, and the requested size code, burst code and direction. A request on an edge with `bus_ready` low leaves the type at IDLE.
- R3: On any edge with `bus_ready` low, the address, transfer type, size and burst outputs keep their values.
- R4: For the incrementing burst codes INCR=1, INCR4=3, INCR8=5 and INCR16=7, beat k has address start + k·2^size, modulo 2^32.
- R5: For the wrapping burst codes WRAP4=2, WRAP8=4 and WRAP16=6, with N = 4, 8 or 16 and region R = N·2^size bytes, beat k keeps the address bits above log2(R) from the start. Its low bits are (start + k·2^size) mod R.
- R6: SINGLE (code 0) issues exactly one beat. Codes 2 to 7 issue exactly 4, 8 or 16 beats (a beat is accepted when NONSEQ or SEQ meets `bus_ready` high), and the sequencer then returns to IDLE. `req_more` has no effect on these bursts.
- R7: An INCR (code 1) burst ends with the beat that is accepted while `req_more` is low.
- R8: If `req_hold` is high when a non-final beat is accepted, or while BUSY meets `bus_ready` high, the next type is BUSY (2'b01). Otherwise it is SEQ (2'b11). The address does not change while leaving or staying in BUSY, and the beat position does not advance.
- R9: `burst_done` is high for exactly the one cycle after the final beat is accepted, and the type is IDLE in that cycle.
- R10: `req_start` and `req_addr` have no effect while a burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_start | input | 1 | Request a new burst (sampled while idle) |
| req_addr | input | 32 | Start address of the requested burst |
| req_size | input | 3 | Beat size code; beat bytes = 2^code |
| req_burst | input | 3 | Burst kind code (0..7) |
| req_write | input | 1 | Direction of the requested burst, 1 = write |
| req_hold | input | 1 | Insert a busy cycle before the next beat |
| req_more | input | 1 | Continue an undefined-length burst |
| bus_ready | input | 1 | Bus ready; all address-phase state moves only when high |
| bus_addr | output | 32 | Address of the current beat |
| bus_trans | output | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| bus_burst | output | 3 | Burst kind of the current burst |
| bus_size | output | 3 | Beat size code of the current burst |
| bus_write | output | 1 | Direction of the current burst |
| burst_done | output | 1 | One-cycle pulse after the final beat is accepted |

## Verification
The hardest case to reach is a 16-beat wrapping burst at a large beat size whose start sits off the region base. The bench must also mix in busy cycles and ready stalls so that the fold to the region base lands on a beat that was held or stalled. The bench sweeps every burst code against several size codes, including the largest, and against start addresses chosen to sit part-way into their region. Each combination runs twice: once with ready and hold steady, and once with pseudo-random ready drops, busy insertions, stray start requests and toggling of the continue input. Every beat address is compared against a closed-form value computed from its beat index.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [2:0] {
    BT_SINGLE = 3'd0,
    BT_INCR   = 3'd1,
    BT_WRAP4  = 3'd2,
    BT_INCR4  = 3'd3,
    BT_WRAP8  = 3'd4,
    BT_INCR8  = 3'd5,
    BT_WRAP16 = 3'd6,
    BT_INCR16 = 3'd7
  } burst_e;

  // log2 of the fixed beat count; 0 for single and undefined-length
  function automatic logic [2:0] len_log2(burst_e b);
    case (b)
      BT_WRAP4, BT_INCR4:   return 3'd2;
      BT_WRAP8, BT_INCR8:   return 3'd3;
      BT_WRAP16, BT_INCR16: return 3'd4;
      default:              return 3'd0;
    endcase
  endfunction

  function automatic logic is_wrap(burst_e b);
    return (b == BT_WRAP4) || (b == BT_WRAP8) || (b == BT_WRAP16);
  endfunction

endpackage

// File: rtl/bsq_addr_step.sv
module bsq_addr_step
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [SIZE_W-1:0] size_code,
  input  burst_e            burst_code,
  output logic [ADDR_W-1:0] nxt_addr
);

  localparam int LG_W = SIZE_W + 1;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] region_mask;
  logic [LG_W-1:0]   region_lg;

  always_comb begin
    step        = {{(ADDR_W-1){1'b0}}, 1'b1} << size_code;
    sum         = cur_addr + step;
    region_lg   = LG_W'(size_code) + LG_W'(len_log2(burst_code));
    region_mask = ({{(ADDR_W-1){1'b0}}, 1'b1} << region_lg) - {{(ADDR_W-1){1'b0}}, 1'b1};
    if (is_wrap(burst_code)) begin
      nxt_addr = (cur_addr & ~region_mask) | (sum & region_mask);
    end else begin
      nxt_addr = sum;
    end
  end

endmodule

// File: rtl/bsq_beat_track.sv
module bsq_beat_track
  import bsq_pkg::*;
#(
  parameter int MAX_BEATS = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  logic   advance,
  input  burst_e burst_code,
  input  logic   keep_going,
  output logic   is_last
);

  localparam int CNT_W = $clog2(MAX_BEATS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
    end else if (advance) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    lim = CNT_W'((32'd1 << len_log2(burst_code)) - 32'd1);
    if (burst_code == BT_INCR) begin
      is_last = !keep_going;
    end else begin
      is_last = (cnt_q == lim);
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 3,
  parameter int MAX_BEATS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [2:0]        req_burst,
  input  logic              req_write,
  input  logic              req_hold,
  input  logic              req_more,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_trans,
  output logic [2:0]        bus_burst,
  output logic [SIZE_W-1:0] bus_size,
  output logic              bus_write,
  output logic              burst_done
);

  trans_e            trans_q;
  burst_e            burst_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic              write_q;
  logic              done_q;

  logic [ADDR_W-1:0] addr_nxt;
  logic              beat_live;
  logic              take_start;
  logic              take_beat;
  logic              last_beat;
  logic              step_beat;

  assign beat_live  = (trans_q == TR_NSEQ) || (trans_q == TR_SEQ);
  assign take_start = bus_ready && (trans_q == TR_IDLE) && req_start;
  assign take_beat  = bus_ready && beat_live;
  assign step_beat  = take_beat && !last_beat;

  bsq_addr_step #(
    .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W)
  ) u_step (
    .cur_addr  (addr_q),
    .size_code (size_q),
    .burst_code(burst_q),
    .nxt_addr  (addr_nxt)
  );

  bsq_beat_track #(
    .MAX_BEATS(MAX_BEATS)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .load      (take_start),
    .advance   (step_beat),
    .burst_code(burst_q),
    .keep_going(req_more),
    .is_last   (last_beat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trans_q <= TR_IDLE;
      burst_q <= BT_SINGLE;
      addr_q  <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= take_beat && last_beat;
      if (bus_ready) begin
        case (trans_q)
          TR_IDLE: begin
            if (req_start) begin
              addr_q  <= req_addr;
              size_q  <= req_size;
              burst_q <= burst_e'(req_burst);
              write_q <= req_write;
              trans_q <= TR_NSEQ;
            end
          end
          TR_NSEQ, TR_SEQ: begin
            if (last_beat) begin
              trans_q <= TR_IDLE;
            end else begin
              addr_q  <= addr_nxt;
              trans_q <= req_hold ? TR_BUSY : TR_SEQ;
            end
          end
          TR_BUSY: begin
            trans_q <= req_hold ? TR_BUSY : TR_SEQ;
          end
          default: trans_q <= TR_IDLE;
        endcase
      end
    end
  end

  assign bus_addr   = addr_q;
  assign bus_trans  = trans_q;
  assign bus_burst  = burst_q;
  assign bus_size   = size_q;
  assign bus_write  = write_q;
  assign burst_done = done_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_start,
  input logic [ADDR_W-1:0] req_addr,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_trans,
  input logic [2:0]        bus_burst,
  input logic [SIZE_W-1:0] bus_size,
  input logic              burst_done
);

  logic rst_seen;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
  end

  // R1: the cycle after a reset edge is idle with no completion pulse
  always @(negedge clk) begin
    if (rst_seen) begin
      a_r1_reset_idle: assert (bus_trans == 2'b00 && !burst_done);
    end
  end

  a_r2_start_nonseq: assert property (@(posedge clk) disable iff (rst)
    (bus_trans == 2'b00 && bus_ready && req_start) |=>
      (bus_trans == 2'b10 && bus_addr == $past(req_addr)));

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |=> ($stable(bus_addr) && $stable(bus_trans) &&
                    $stable(bus_burst) && $stable(bus_size)));

  a_r4_incr_step: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && bus_trans[1] && bus_burst[0]) |=>
      (bus_trans == 2'b00 ||
       bus_addr == $past(bus_addr) + ({{(ADDR_W-1){1'b0}}, 1'b1} << $past(bus_size))));

  a_r8_busy_addr_held: assert property (@(posedge clk) disable iff (rst)
    (bus_trans == 2'b01 && bus_ready) |=>
      (bus_addr == $past(bus_addr) && (bus_trans == 2'b01 || bus_trans == 2'b11)));

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> bus_trans == 2'b00);

  a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> !burst_done);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W(ADDR_W),
  .SIZE_W(SIZE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_start (req_start),
  .req_addr  (req_addr),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_trans (bus_trans),
  .bus_burst (bus_burst),
  .bus_size  (bus_size),
  .burst_done(burst_done)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [2:0]  req_burst = '0;
  logic        req_write = 1'b0;
  logic        req_hold = 1'b0;
  logic        req_more = 1'b1;
  logic        bus_ready = 1'b1;
  logic [31:0] bus_addr;
  logic [1:0]  bus_trans;
  logic [2:0]  bus_burst;
  logic [2:0]  bus_size;
  logic        bus_write;
  logic        burst_done;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
    .req_size(req_size), .req_burst(req_burst), .req_write(req_write),
    .req_hold(req_hold), .req_more(req_more), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_trans(bus_trans), .bus_burst(bus_burst),
    .bus_size(bus_size), .bus_write(bus_write), .burst_done(burst_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int beats_of(input int bc, input int ilen);
    case (bc)
      0: return 1;
      1: return ilen;
      2, 3: return 4;
      4, 5: return 8;
      default: return 16;
    endcase
  endfunction

  // closed-form beat address from the requirements (R4, R5)
  function automatic logic [31:0] exp_addr(input logic [31:0] st, input int sz,
                                           input int bc, input int k);
    logic [31:0] bytes;
    logic [31:0] lin;
    logic [31:0] mask;
    int lg;
    bytes = 32'd1 << sz;
    lin   = st + bytes * k;
    lg    = (bc == 2) ? 2 : (bc == 4) ? 3 : (bc == 6) ? 4 : 0;
    if (lg == 0) return lin;
    mask = (32'd1 << (sz + lg)) - 32'd1;
    return (st & ~mask) | (lin & mask);
  endfunction

  task automatic run_burst(input logic [31:0] st, input int sz, input int bc,
                           input bit wr, input int ilen, input bit stress);
    int          len;
    int          k;
    bit          fin;
    bit          r;
    bit          h;
    bit          kg;
    bit          sp;
    logic [1:0]  cur_t;
    logic [31:0] cur_a;
    logic [31:0] ea;
    len = beats_of(bc, ilen);
    req_addr  = st;
    req_size  = 3'(sz);
    req_burst = 3'(bc);
    req_write = wr;
    req_start = 1'b1;
    req_hold  = 1'b0;
    req_more  = 1'b1;
    bus_ready = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    check(bus_trans == 2'b10 && bus_addr == st, "R2 nonseq+addr",
          {bus_trans, bus_addr[29:0]}, {2'b10, st[29:0]});
    check(bus_size == 3'(sz) && bus_burst == 3'(bc) && bus_write == wr, "R2 control",
          {25'd0, bus_size, bus_burst, bus_write}, {25'd0, 3'(sz), 3'(bc), wr});
    k = 0;
    fin = 0;
    while (!fin) begin
      cur_t = bus_trans;
      cur_a = bus_addr;
      r  = stress ? ($urandom % 4 != 0) : 1'b1;
      h  = stress ? ($urandom % 3 == 0) : 1'b0;
      sp = stress ? ($urandom % 2 == 0) : 1'b0;
      if (bc == 1) kg = (k < len - 1);
      else kg = stress ? ($urandom % 2 == 0) : 1'b1;
      bus_ready = r;
      req_hold  = h;
      req_more  = kg;
      req_start = sp;
      req_addr  = sp ? $urandom : st;
      @(negedge clk);
      if (!r) begin
        check(bus_addr == cur_a && bus_trans == cur_t, "R3 stall holds",
              bus_addr, cur_a);
      end else if (cur_t == 2'b10 || cur_t == 2'b11) begin
        if (k == len - 1) begin
          check(bus_trans == 2'b00 && burst_done,
                (bc == 1) ? "R7 end on req_more low" : "R6 beat count end",
                {30'd0, bus_trans}, 32'd0);
          fin = 1;
        end else begin
          k++;
          ea = exp_addr(st, sz, bc, k);
          check(bus_addr == ea,
                sp ? "R10 start ignored" : ((bc == 2 || bc == 4 || bc == 6) ? "R5 wrap addr" : "R4 incr addr"),
                bus_addr, ea);
          check(bus_trans == (h ? 2'b01 : 2'b11) && !burst_done, "R8 type after beat",
                {30'd0, bus_trans}, {30'd0, (h ? 2'b01 : 2'b11)});
        end
      end else begin
        check(bus_addr == cur_a && bus_trans == (h ? 2'b01 : 2'b11), "R8 busy holds",
              bus_addr, cur_a);
      end
    end
    req_start = 1'b0;
    req_hold  = 1'b0;
    bus_ready = 1'b1;
    @(negedge clk);
    check(!burst_done && bus_trans == 2'b00, "R9 done one cycle",
          {30'd0, burst_done, bus_trans[0]}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!ended) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int szs [5];
    logic [31:0] starts [3];
    int run_no;
    szs    = '{0, 1, 2, 3, 7};
    starts = '{32'h0000_0000, 32'h2000_0A74, 32'hFFFF_FFE8};
    run_no = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(bus_trans == 2'b00 && !burst_done, "R1 reset idle",
          {30'd0, bus_trans}, 32'd0);

    // R2: request with ready low is not taken
    req_start = 1'b1;
    req_addr  = 32'h1234_5678;
    bus_ready = 1'b0;
    @(negedge clk);
    check(bus_trans == 2'b00, "R2 no start without ready", {30'd0, bus_trans}, 32'd0);
    req_start = 1'b0;
    bus_ready = 1'b1;
    @(negedge clk);

    for (int stress = 0; stress < 2; stress++) begin
      for (int bc = 0; bc < 8; bc++) begin
        foreach (szs[i]) begin
          foreach (starts[j]) begin
            logic [31:0] st;
            st = starts[j] & ~((32'd1 << szs[i]) - 32'd1);
            run_burst(st, szs[i], bc, run_no[0], 1 + (run_no % 5), stress[0]);
            run_no++;
          end
        end
      end
    end

    // R1: reset in the middle of a burst returns to idle
    req_addr = 32'h0000_0100; req_size = 3'd2; req_burst = 3'd7;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(bus_trans == 2'b00 && !burst_done, "R1 reset mid-burst",
          {30'd0, bus_trans}, 32'd0);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule